// File: doc/BRIEF.md
# ATA PIO Cycle Timing Sequencer

This block carries out one programmed-I/O register or data transfer on the device side of an ATA disk interface. A host-side agent presents a request for one cycle. The request holds a read/write flag, a 3-bit register address, a bank select that picks one of the two active-low chip selects, and a 16-bit write word. The sequencer then runs the bus cycle as four phases, each counted in clock cycles: address setup, strobe active, strobe-to-release hold and end-of-cycle recovery. At the end it raises a one-cycle completion pulse. On a read, the word taken from the device bus is then available on the read-data output.

All four phase lengths are parameters, and one down-counter of parameterised width times every phase. The device can hold the strobe phase open by keeping its ready line low. Every device-side output comes from a flop, so the bus sees no decode glitches. The block also drives an active-low device reset under host control. It holds the DMA acknowledge line inactive at all times.

Top module: `pio_xfer_seq`

## Requirements
- R1: While no transfer is in progress (busy low, including straight after reset), both chip selects and both strobes are high and the data output enable is low.
- R2: A request is accepted on the first rising edge at which req_valid is high and busy is low. From that edge, for P_SETUP cycles, da carries the requested address and the selected chip select is low (req_bank 0 selects cs0_n, req_bank 1 selects cs1_n) while both strobes stay high. The other chip select stays high for the whole transfer.
- R3: After address setup, dior_n (read) or diow_n (write) is low for P_STROBE cycles, and the other strobe stays high.
- R4: If iordy is low at the edge that would end the strobe phase, the strobe phase continues until the first edge at which iordy is high. The later phases keep their lengths.
- R5: After the strobe phase there are P_HOLD cycles in which both strobes are high while the chip select and da keep their values.
- R6: Then come P_RECOV recovery cycles in which both chip selects are high and the output enable is low. At the edge that ends recovery, done goes high for exactly one cycle and busy falls in the same cycle.
- R7: On a write, dd_out carries the request's write word and dd_oe is high from acceptance to the end of the hold phase. On a read, dd_oe stays low.
- R8: On a read, rdata takes the value on dd_in at the rising edge that ends the strobe phase. rdata keeps that value until the next read completes, and writes leave it unchanged.
- R9: busy is high from the acceptance edge until done. A request presented while busy is ignored and does not change the transfer in progress.
- R10: dev_rst_n is low during block reset. After that it is the registered inverse of host_dev_rst, one cycle behind.
- R11: dmack_n is high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| req_valid | input | 1 | Transfer request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Device register address |
| req_bank | input | 1 | Chip-select bank: 0 = cs0_n, 1 = cs1_n |
| req_wdata | input | 16 | Write word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last word read from the device |
| host_dev_rst | input | 1 | Host request to hold the device in reset |
| dev_rst_n | output | 1 | Active-low device reset |
| dd_in | input | 16 | Device data bus, inbound |
| dd_out | output | 16 | Device data bus, outbound |
| dd_oe | output | 1 | Outbound data enable |
| da | output | 3 | Device register address |
| cs0_n | output | 1 | Chip select, bank 0, active low |
| cs1_n | output | 1 | Chip select, bank 1, active low |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| iordy | input | 1 | Device ready; low stretches the strobe |
| dmack_n | output | 1 | DMA acknowledge, held inactive |

## Verification
The bench compares every output against a phase schedule it computes from the phase lengths, every cycle, for all addresses, both banks, both directions and several ready-stretch lengths. If the counter reload were off by one, a phase boundary would move by a cycle and the per-cycle compare would catch it. If ready were ignored, or checked at the wrong point, the strobe would end early. dd_in changes every cycle, so a read capture taken one edge early or late returns a neighbouring word. Requests poked in mid-transfer would change the address of a design that latches while busy, and a done that lasted two cycles, or a busy that fell early, shows up at the end of each transfer.

// File: rtl/pio_xfer_pkg.sv
package pio_xfer_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_RECOV
    } phase_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic              bank;
        logic [DATA_W-1:0] wdata;
    } xfer_req_t;

endpackage

// File: rtl/pio_phase_timer.sv
module pio_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pio_seq_ctrl.sv
module pio_seq_ctrl
    import pio_xfer_pkg::*;
#(
    parameter int P_SETUP  = 6,
    parameter int P_STROBE = 28,
    parameter int P_HOLD   = 2,
    parameter int P_RECOV  = 23,
    parameter int CNT_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  xfer_req_t         req_in,
    input  logic              iordy,
    input  logic [DATA_W-1:0] dd_in,
    input  logic              timer_expired,
    output logic              timer_load,
    output logic [CNT_W-1:0]  timer_val,
    output phase_e            phase_nx,
    output xfer_req_t         req_nx,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [CNT_W-1:0] LD_SETUP  = CNT_W'(P_SETUP - 1);
    localparam logic [CNT_W-1:0] LD_STROBE = CNT_W'(P_STROBE - 1);
    localparam logic [CNT_W-1:0] LD_HOLD   = CNT_W'(P_HOLD - 1);
    localparam logic [CNT_W-1:0] LD_RECOV  = CNT_W'(P_RECOV - 1);

    typedef struct packed {
        phase_e            phase;
        xfer_req_t         req;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } ctrl_st_t;

    ctrl_st_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        timer_load = 1'b0;
        timer_val  = '0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.req    = req_in;
                    s_d.phase  = PH_SETUP;
                    timer_load = 1'b1;
                    timer_val  = LD_SETUP;
                end
            end
            PH_SETUP: begin
                if (timer_expired) begin
                    s_d.phase  = PH_STROBE;
                    timer_load = 1'b1;
                    timer_val  = LD_STROBE;
                end
            end
            PH_STROBE: begin
                // the device may extend the strobe by holding ready low
                if (timer_expired && iordy) begin
                    s_d.phase  = PH_HOLD;
                    timer_load = 1'b1;
                    timer_val  = LD_HOLD;
                    if (!s_q.req.wr) begin
                        s_d.rdata = dd_in;
                    end
                end
            end
            PH_HOLD: begin
                if (timer_expired) begin
                    s_d.phase  = PH_RECOV;
                    timer_load = 1'b1;
                    timer_val  = LD_RECOV;
                end
            end
            PH_RECOV: begin
                if (timer_expired) begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                end
            end
            default: begin
                s_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase <= PH_IDLE;
            s_q.req   <= '0;
            s_q.done  <= 1'b0;
            s_q.rdata <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_nx = s_d.phase;
    assign req_nx   = s_d.req;
    assign busy     = (s_q.phase != PH_IDLE);
    assign done     = s_q.done;
    assign rdata    = s_q.rdata;

endmodule

// File: rtl/pio_pad_drive.sv
module pio_pad_drive
    import pio_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase_nx,
    input  xfer_req_t         req_nx,
    input  logic              host_dev_rst,
    output logic [ADDR_W-1:0] da,
    output logic              cs0_n,
    output logic              cs1_n,
    output logic              dior_n,
    output logic              diow_n,
    output logic [DATA_W-1:0] dd_out,
    output logic              dd_oe,
    output logic              dev_rst_n
);

    typedef struct packed {
        logic [ADDR_W-1:0] da;
        logic [1:0]        cs_n;
        logic              rd_n;
        logic              wr_n;
        logic [DATA_W-1:0] dout;
        logic              oe;
        logic              drst_n;
    } pad_st_t;

    pad_st_t s_d, s_q;
    logic    selecting;

    always_comb begin
        selecting = (phase_nx == PH_SETUP) || (phase_nx == PH_STROBE)
                 || (phase_nx == PH_HOLD);
        s_d        = s_q;
        s_d.da     = req_nx.addr;
        s_d.dout   = req_nx.wdata;
        s_d.cs_n   = 2'b11;
        s_d.rd_n   = 1'b1;
        s_d.wr_n   = 1'b1;
        s_d.oe     = 1'b0;
        s_d.drst_n = ~host_dev_rst;
        if (selecting) begin
            s_d.cs_n[req_nx.bank] = 1'b0;
            s_d.oe                = req_nx.wr;
        end
        if (phase_nx == PH_STROBE) begin
            s_d.rd_n = req_nx.wr;
            s_d.wr_n = ~req_nx.wr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.da     <= '0;
            s_q.cs_n   <= 2'b11;
            s_q.rd_n   <= 1'b1;
            s_q.wr_n   <= 1'b1;
            s_q.dout   <= '0;
            s_q.oe     <= 1'b0;
            s_q.drst_n <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign da        = s_q.da;
    assign cs0_n     = s_q.cs_n[0];
    assign cs1_n     = s_q.cs_n[1];
    assign dior_n    = s_q.rd_n;
    assign diow_n    = s_q.wr_n;
    assign dd_out    = s_q.dout;
    assign dd_oe     = s_q.oe;
    assign dev_rst_n = s_q.drst_n;

endmodule

// File: rtl/pio_xfer_seq.sv
module pio_xfer_seq
    import pio_xfer_pkg::*;
#(
    parameter int P_SETUP  = 6,
    parameter int P_STROBE = 28,
    parameter int P_HOLD   = 2,
    parameter int P_RECOV  = 23,
    parameter int CNT_W    = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [2:0]  req_addr,
    input  logic        req_bank,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata,
    input  logic        host_dev_rst,
    output logic        dev_rst_n,
    input  logic [15:0] dd_in,
    output logic [15:0] dd_out,
    output logic        dd_oe,
    output logic [2:0]  da,
    output logic        cs0_n,
    output logic        cs1_n,
    output logic        dior_n,
    output logic        diow_n,
    input  logic        iordy,
    output logic        dmack_n
);

    xfer_req_t        req_in;
    xfer_req_t        req_nx;
    phase_e           phase_nx;
    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    logic             timer_expired;

    assign req_in.wr    = req_write;
    assign req_in.addr  = req_addr;
    assign req_in.bank  = req_bank;
    assign req_in.wdata = req_wdata;

    pio_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (timer_expired)
    );

    pio_seq_ctrl #(
        .P_SETUP  (P_SETUP),
        .P_STROBE (P_STROBE),
        .P_HOLD   (P_HOLD),
        .P_RECOV  (P_RECOV),
        .CNT_W    (CNT_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_in        (req_in),
        .iordy         (iordy),
        .dd_in         (dd_in),
        .timer_expired (timer_expired),
        .timer_load    (timer_load),
        .timer_val     (timer_val),
        .phase_nx      (phase_nx),
        .req_nx        (req_nx),
        .busy          (busy),
        .done          (done),
        .rdata         (rdata)
    );

    pio_pad_drive u_pads (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase_nx     (phase_nx),
        .req_nx       (req_nx),
        .host_dev_rst (host_dev_rst),
        .da           (da),
        .cs0_n        (cs0_n),
        .cs1_n        (cs1_n),
        .dior_n       (dior_n),
        .diow_n       (diow_n),
        .dd_out       (dd_out),
        .dd_oe        (dd_oe),
        .dev_rst_n    (dev_rst_n)
    );

    assign dmack_n = 1'b1;

endmodule

// File: rtl/pio_xfer_seq_chk.sv
module pio_xfer_seq_chk #(
    parameter int P_SETUP = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       cs0_n,
    input logic       cs1_n,
    input logic       dior_n,
    input logic       diow_n,
    input logic       dd_oe,
    input logic       dmack_n,
    input logic [2:0] da
);

    // cycles spent selected with no strobe low, cleared when deselected
    int setup_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            setup_seen <= 0;
        end else if (cs0_n && cs1_n) begin
            setup_seen <= 0;
        end else if (dior_n && diow_n && setup_seen <= P_SETUP) begin
            setup_seen <= setup_seen + 1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs0_n && cs1_n && dior_n && diow_n && !dd_oe));

    assert_one_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!cs0_n && !cs1_n));

    assert_setup_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dior_n) || $fell(diow_n)) |-> (setup_seen == P_SETUP));

    assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dior_n && !diow_n));

    assert_strobe_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dior_n || !diow_n) |-> (!cs0_n || !cs1_n));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_write_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !diow_n |-> dd_oe);

    assert_read_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dior_n |-> !dd_oe);

    assert_addr_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(da)));

    assert_dmack_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dmack_n);

endmodule

bind pio_xfer_seq pio_xfer_seq_chk #(.P_SETUP(P_SETUP)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .cs0_n   (cs0_n),
    .cs1_n   (cs1_n),
    .dior_n  (dior_n),
    .diow_n  (diow_n),
    .dd_oe   (dd_oe),
    .dmack_n (dmack_n),
    .da      (da)
);

// File: tb/pio_xfer_seq_test.sv
`timescale 1ns/1ps
module pio_xfer_seq_test;

    localparam int T_SU = 3;
    localparam int T_ST = 4;
    localparam int T_HD = 2;
    localparam int T_RC = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_addr = '0;
    logic        req_bank = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        busy, done;
    logic [15:0] rdata;
    logic        host_dev_rst = 1'b0;
    logic        dev_rst_n;
    logic [15:0] dd_in = '0;
    logic [15:0] dd_out;
    logic        dd_oe;
    logic [2:0]  da;
    logic        cs0_n, cs1_n, dior_n, diow_n;
    logic        iordy = 1'b1;
    logic        dmack_n;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [15:0] last_rd = '0;

    always #4 clk = ~clk;

    pio_xfer_seq #(
        .P_SETUP(T_SU), .P_STROBE(T_ST), .P_HOLD(T_HD), .P_RECOV(T_RC), .CNT_W(4)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_bank(req_bank), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata), .host_dev_rst(host_dev_rst),
        .dev_rst_n(dev_rst_n), .dd_in(dd_in), .dd_out(dd_out), .dd_oe(dd_oe),
        .da(da), .cs0_n(cs0_n), .cs1_n(cs1_n), .dior_n(dior_n), .diow_n(diow_n),
        .iordy(iordy), .dmack_n(dmack_n)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // pins packed as {busy,done,cs0_n,cs1_n,dior_n,diow_n,dd_oe,da,dmack_n}
    function automatic logic [10:0] pins();
        return {busy, done, cs0_n, cs1_n, dior_n, diow_n, dd_oe, da, dmack_n};
    endfunction

    task automatic run_xfer(input bit wr, input logic [2:0] a, input bit bk,
                            input logic [15:0] wd, input int stretch,
                            input bit poke, input logic [15:0] base);
        int strobe_end, total;
        strobe_end = T_SU + T_ST + stretch;
        total      = strobe_end + T_HD + T_RC;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_bank = bk;
        req_wdata = wd; iordy = 1'b1; dd_in = base;
        @(posedge clk);
        for (int m = 0; m <= total + 1; m++) begin
            logic [10:0] exp;
            bit sel, stb, act;
            @(negedge clk);
            // R9: a foreign request while busy must be ignored
            req_valid = poke && (m == 1);
            if (poke && m == 1) begin
                req_write = ~wr; req_addr = ~a; req_bank = ~bk; req_wdata = ~wd;
            end
            act = (m < total);
            sel = (m < strobe_end + T_HD);
            stb = (m >= T_SU) && (m < strobe_end);
            exp = {act, (m == total),
                   !(sel && !bk), !(sel && bk),
                   !(stb && !wr), !(stb && wr),
                   (sel && wr), a, 1'b1};
            // R1 R2 R3 R4 R5 R6 R9 R11 cycle schedule
            check("R2/R3/R4/R5/R6 pins", 32'(pins()), 32'(exp));
            if (sel && wr) check("R7 dd_out", 32'(dd_out), 32'(wd));
            if (m == total) begin
                if (!wr) last_rd = base + 16'(strobe_end);
                check("R8 rdata", 32'(rdata), 32'(last_rd));
            end
            iordy = (m + 1 >= strobe_end);
            dd_in = base + 16'(m + 1);
        end
        req_valid = 1'b0;
        iordy = 1'b1;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1 and R10 in reset
        check("R1 reset pins", 32'(pins()), 32'({1'b0, 1'b0, 4'b1111, 1'b0, 3'b000, 1'b1}));
        check("R10 reset dev_rst_n", 32'(dev_rst_n), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 released", 32'(dev_rst_n), 32'd1);
        host_dev_rst = 1'b1;
        @(negedge clk);
        check("R10 host assert", 32'(dev_rst_n), 32'd0);
        host_dev_rst = 1'b0;
        @(negedge clk);
        check("R10 host release", 32'(dev_rst_n), 32'd1);
        check("R1 idle pins", 32'(pins()), 32'({1'b0, 1'b0, 4'b1111, 1'b0, 3'b000, 1'b1}));

        for (int s = 0; s < 3; s++) begin
            for (int wr = 0; wr < 2; wr++) begin
                for (int bk = 0; bk < 2; bk++) begin
                    for (int a = 0; a < 8; a++) begin
                        int st;
                        logic [15:0] b;
                        st = (s == 2) ? 3 : s;
                        b = 16'h4000 + 16'((s * 32 + wr * 16 + bk * 8 + a) * 64);
                        run_xfer(wr[0], 3'(a), bk[0], 16'hC3A0 ^ 16'(a * 257 + bk * 4099 + s),
                                 st, (a == 5), b);
                    end
                end
            end
        end

        // R9: nothing starts after the last transfer once requests stop
        repeat (3) @(negedge clk);
        check("R9 stays idle", 32'(busy), 32'd0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule